// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer that runs from a slow clock. A 12-bit down-counter moves one step every 128 slow-clock cycles. It raises a fault when it counts past zero, or when a restart arrives while the count is still above a programmed window threshold. A fault can start a full-system reset pulse or a core-only reset pulse, can set a pending interrupt, or can do any allowed mix of these.

Software reaches the block through a small register bus with four word addresses. Address 0 takes the key-protected restart command. Address 1 holds the mode word, which accepts only one write per reset. Address 2 holds the fault status, which clears when it is read. Address 3 returns the live count. The watchdog starts counting from a default mode as soon as reset is released. Once the disable bit has been written, it stays off until the next reset. Two halt bits let the count freeze while the core is idle or held by a debugger.

Top module: `wdt_core`

## Requirements
- R1: The count drops by one every 128 slow-clock cycles. With load value L, an underflow fault occurs on the 128*(L+1)-th clock edge after the restart edge or after the first edge following reset release, and the count then reloads L.
- R2: After reset, the mode word reads back at address 1 as load = DFLT_LOAD, delta = DFLT_LOAD and reset-enable set. The watchdog counts under this mode without any write.
- R3: Only the first write to the mode word (address 1) after reset takes effect. Later writes change neither the readback nor the behaviour. Mode bit layout: load [11:0], fault-interrupt enable [12], reset enable [13], core-only reset [14], disable [15], delta [27:16], idle-halt [29:28 → bit 28], debug-halt [bit 29].
- R4: With disable (bit 15) set, the count is frozen, no fault occurs, and restart commands are ignored.
- R5: A write to address 0 restarts the watchdog only when bits [31:24] equal 8'hA5 and bit 0 is 1. A restart reloads the count from the load field and restarts the 128-cycle step. Any other control write has no effect.
- R6: A restart that is accepted while the count is strictly greater than the delta field is a window error. It sets status bit 1 and is a fault. An underflow sets status bit 0. A restart with the count equal to delta is not an error.
- R7: If reset enable is set and core-only is clear, a fault pulses `sys_rst_o`. If both are set, a fault pulses `cpu_rst_o` only. If reset enable is clear, neither output pulses.
- R8: Each reset pulse goes high on the clock edge of the fault and stays high for exactly 4 cycles.
- R9: `irq_o` is high while fault-interrupt enable is set and any status bit is set. A read of address 2 returns {30'b0, status} and clears the status, so the interrupt drops.
- R10: With idle-halt (bit 28) set, the count and the step divider freeze while `idle_i` is high. With debug-halt (bit 29) set, they freeze while `dbg_halt_i` is high.
- R11: Read data appears on `bus_rdata_o` one cycle after the read strobe. Address 3 returns the current count in bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all state |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Word address: 0 control, 1 mode, 2 status, 3 count |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| idle_i | input | 1 | Core is idle |
| dbg_halt_i | input | 1 | Core is halted by a debugger |
| irq_o | output | 1 | Fault interrupt, level |
| sys_rst_o | output | 1 | Full-system reset pulse |
| cpu_rst_o | output | 1 | Core-only reset pulse |

## Verification
A restart or mode write takes effect on the edge that samples the strobe. An underflow is due exactly 128*(L+1) edges after that edge. The bench therefore counts falling edges from the point where a write task returns, and samples one edge before the due edge and on it. A window error, the interrupt and the reset pulse follow on the same edge as the restart that causes them, so they are checked at the falling edge right after that write. Read data and the clearing of the status are checked one cycle after the read strobe. A pulse is checked on its first cycle, its fourth cycle and the cycle after it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CW = 12;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_MODE = 2'd1,
        A_STAT = 2'd2,
        A_CNT  = 2'd3
    } addr_e;

    typedef struct packed {
        logic          dbg_hlt;
        logic          idle_hlt;
        logic [CW-1:0] delta;
        logic          dis;
        logic          cpu_only;
        logic          rst_en;
        logic          irq_en;
        logic [CW-1:0] load;
    } mode_t;

    typedef struct packed {
        mode_t       mode;
        logic        locked;
        logic [1:0]  stat;
        logic [31:0] rdata;
    } top_st_t;

    function automatic mode_t mode_unpack(input logic [31:0] w);
        mode_t m;
        m.load     = w[11:0];
        m.irq_en   = w[12];
        m.rst_en   = w[13];
        m.cpu_only = w[14];
        m.dis      = w[15];
        m.delta    = w[27:16];
        m.idle_hlt = w[28];
        m.dbg_hlt  = w[29];
        return m;
    endfunction

    function automatic logic [31:0] mode_pack(input mode_t m);
        return {2'b00, m.dbg_hlt, m.idle_hlt, m.delta, m.dis, m.cpu_only,
                m.rst_en, m.irq_en, m.load};
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRESC = 128
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign tick_o = run_i && !clr_i && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R10: a frozen divider holds its phase
    a_r10_frozen_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clr_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter logic [CW-1:0] DFLT_LOAD = '1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          reload_i,
    input  logic [CW-1:0] load_i,
    input  logic [CW-1:0] delta_i,
    output logic [CW-1:0] cnt_o,
    output logic          under_o,
    output logic          win_err_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign cnt_o     = st_q.cnt;
    assign win_err_o = reload_i && (st_q.cnt > delta_i);
    assign under_o   = tick_i && !reload_i && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (reload_i) begin
            st_d.cnt = load_i;
        end else if (tick_i) begin
            st_d.cnt = (st_q.cnt == '0) ? load_i : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: DFLT_LOAD};
        else         st_q <= st_d;
    end

    // R1: one step down per divider tick
    a_r1_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !reload_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R1: no movement without a tick or reload
    a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !reload_i) |=> $stable(st_q.cnt));

    // R5: reload loads the load field
    a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_i |=> (st_q.cnt == $past(load_i)));

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int LW = $clog2(LEN + 1);

    typedef struct packed {
        logic [LW-1:0] left;
    } pls_st_t;

    pls_st_t st_d, st_q;

    assign pulse_o = (st_q.left != '0);

    always_comb begin
        st_d = st_q;
        if (fire_i)                st_d.left = LW'(LEN);
        else if (st_q.left != '0)  st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R8: the pulse rises only on a fire request
    a_r8_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pulse_o && !fire_i) |=> !pulse_o);

    // R8: a fire request always shows on the next cycle
    a_r8_fire_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> pulse_o);

    // R8: the pulse ends after its last counted cycle
    a_r8_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.left == LW'(1) && !fire_i) |=> !pulse_o);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int             PRESC     = 128,
    parameter int             PULSE_LEN = 4,
    parameter logic [7:0]     KEY       = 8'hA5,
    parameter logic [CW-1:0]  DFLT_LOAD = '1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bus_wr_i,
    input  logic        bus_rd_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    input  logic        idle_i,
    input  logic        dbg_halt_i,
    output logic        irq_o,
    output logic        sys_rst_o,
    output logic        cpu_rst_o
);
    localparam int NOUT = 2;

    localparam mode_t DFLT_MODE = '{
        dbg_hlt: 1'b0, idle_hlt: 1'b0, delta: DFLT_LOAD, dis: 1'b0,
        cpu_only: 1'b0, rst_en: 1'b1, irq_en: 1'b0, load: DFLT_LOAD};

    top_st_t st_d, st_q;

    logic          restart, halt, run, tick, under, win_err, fault;
    logic [CW-1:0] cnt;
    logic [NOUT-1:0] fire, pulse;

    assign restart = bus_wr_i && (bus_addr_i == A_CTRL) && (bus_wdata_i[31:24] == KEY)
                     && bus_wdata_i[0] && !st_q.mode.dis;
    assign halt    = (st_q.mode.idle_hlt && idle_i) || (st_q.mode.dbg_hlt && dbg_halt_i);
    assign run     = !st_q.mode.dis && !halt;
    assign fault   = under || win_err;

    assign fire[0] = fault && st_q.mode.rst_en && !st_q.mode.cpu_only;
    assign fire[1] = fault && st_q.mode.rst_en &&  st_q.mode.cpu_only;

    wdt_prescale #(.PRESC(PRESC)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .clr_i  (restart),
        .tick_o (tick)
    );

    wdt_count #(.DFLT_LOAD(DFLT_LOAD)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .reload_i  (restart),
        .load_i    (st_q.mode.load),
        .delta_i   (st_q.mode.delta),
        .cnt_o     (cnt),
        .under_o   (under),
        .win_err_o (win_err)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_pulse
        wdt_pulse #(.LEN(PULSE_LEN)) u_pls (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .fire_i  (fire[g]),
            .pulse_o (pulse[g])
        );
    end

    assign sys_rst_o   = pulse[0];
    assign cpu_rst_o   = pulse[1];
    assign irq_o       = st_q.mode.irq_en && (st_q.stat != 2'b00);
    assign bus_rdata_o = st_q.rdata;

    always_comb begin
        st_d = st_q;
        if (bus_wr_i && (bus_addr_i == A_MODE) && !st_q.locked) begin
            st_d.mode   = mode_unpack(bus_wdata_i);
            st_d.locked = 1'b1;
        end
        if (bus_rd_i && (bus_addr_i == A_STAT)) st_d.stat = 2'b00;
        if (under)   st_d.stat[0] = 1'b1;
        if (win_err) st_d.stat[1] = 1'b1;
        if (bus_rd_i) begin
            unique case (bus_addr_i)
                A_CTRL:  st_d.rdata = '0;
                A_MODE:  st_d.rdata = mode_pack(st_q.mode);
                A_STAT:  st_d.rdata = {30'b0, st_q.stat};
                default: st_d.rdata = {{(32-CW){1'b0}}, cnt};
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{mode: DFLT_MODE, locked: 1'b0, stat: 2'b00, rdata: '0};
        else         st_q <= st_d;
    end

    // R3: a locked mode word never changes
    a_r3_locked_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.locked |=> $stable(st_q.mode));

    // R4: disabled means a frozen count
    a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.mode.dis |=> $stable(cnt));

    // R5: a control write with a wrong key leaves the count alone
    a_r5_wrong_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_CTRL && bus_wdata_i[31:24] != KEY && !tick) |=> $stable(cnt));

    // R9: a status read with no new fault empties the status
    a_r9_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && bus_addr_i == A_STAT && !fault) |=> (st_q.stat == 2'b00));

    // R7: the two reset requests never fire together
    a_r7_one_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(fire) <= 1);

endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        idle = 1'b0, dbg = 1'b0;
    logic        irq, sys_rst, cpu_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wdt_core #(.DFLT_LOAD(12'd2)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .idle_i(idle), .dbg_halt_i(dbg), .irq_o(irq),
        .sys_rst_o(sys_rst), .cpu_rst_o(cpu_rst)
    );

    // mode word | twice | wait | sys cpu irq | status
    localparam logic [47:0] VEC [0:7] = '{
        {32'h0FFF_2001, 1'b0, 10'd256, 3'b100, 2'b01},
        {32'h0FFF_6001, 1'b0, 10'd256, 3'b010, 2'b01},
        {32'h0FFF_1001, 1'b0, 10'd256, 3'b001, 2'b01},
        {32'h0FFF_3001, 1'b0, 10'd256, 3'b101, 2'b01},
        {32'h0FFF_0001, 1'b0, 10'd256, 3'b000, 2'b01},
        {32'h0002_3003, 1'b1, 10'd0,   3'b101, 2'b10},
        {32'h0002_6003, 1'b1, 10'd0,   3'b010, 2'b10},
        {32'h0002_2002, 1'b1, 10'd0,   3'b000, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr = 1'b0; rd = 1'b0; idle = 1'b0; dbg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [31:0] GO = 32'hA500_0001;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        // reset state
        #1;
        chk("R2 reset sys", {31'b0, sys_rst}, 0);
        chk("R2 reset cpu", {31'b0, cpu_rst}, 0);
        chk("R2 reset irq", {31'b0, irq}, 0);

        // R1 R2 R8: default mode underflows at edge 384 after release
        do_reset();
        wait_n(383);
        chk("R1 before underflow", {31'b0, sys_rst}, 0);
        wait_n(1);
        chk("R2 default reset pulse", {31'b0, sys_rst}, 1);
        wait_n(3);
        chk("R8 pulse 4th cycle", {31'b0, sys_rst}, 1);
        wait_n(1);
        chk("R8 pulse ended", {31'b0, sys_rst}, 0);
        bus_rd(2'd1, r);
        chk("R2 default mode readback", r, 32'h0002_2002);

        // vector table: routing, window, status
        for (int i = 0; i < 8; i++) begin
            logic [47:0] v;
            v = VEC[i];
            do_reset();
            bus_wr(2'd1, v[47:16]);
            bus_wr(2'd0, GO);
            if (v[15]) bus_wr(2'd0, GO);
            wait_n(int'(v[14:5]));
            chk("R7 sys route", {31'b0, sys_rst}, {31'b0, v[4]});
            chk("R7 cpu route", {31'b0, cpu_rst}, {31'b0, v[3]});
            chk("R9 irq", {31'b0, irq}, {31'b0, v[2]});
            bus_rd(2'd2, r);
            chk("R6 status", r, {30'b0, v[1:0]});
            chk("R9 irq after read", {31'b0, irq}, 0);
        end

        // R3: second mode write ignored
        do_reset();
        bus_wr(2'd1, 32'h0FFF_1001);
        bus_wr(2'd1, 32'h0000_8000);
        bus_rd(2'd1, r);
        chk("R3 readback first write", r, 32'h0FFF_1001);
        bus_wr(2'd0, GO);
        wait_n(256);
        chk("R3 first mode active", {31'b0, irq}, 1);

        // R4: disable freezes, restart ignored
        do_reset();
        bus_wr(2'd1, 32'h0000_A002);
        wait_n(1000);
        chk("R4 no fault", {31'b0, sys_rst}, 0);
        bus_wr(2'd0, GO);
        bus_rd(2'd2, r);
        chk("R4 restart ignored", r, 0);
        bus_rd(2'd3, r);
        chk("R4 count frozen", r, 2);

        // R5 R6 R11: key check, window error, reload
        do_reset();
        bus_wr(2'd1, 32'h0000_1003);
        bus_wr(2'd0, 32'h5A00_0001);
        chk("R5 wrong key", {31'b0, irq}, 0);
        bus_wr(2'd0, 32'hA500_0000);
        chk("R5 no restart bit", {31'b0, irq}, 0);
        bus_rd(2'd3, r);
        chk("R11 count before restart", r, 2);
        bus_wr(2'd0, GO);
        chk("R6 window error irq", {31'b0, irq}, 1);
        bus_rd(2'd3, r);
        chk("R5 reload value", r, 3);
        bus_rd(2'd2, r);
        chk("R6 error bit", r, 32'h2);

        // R5: restart pushes the underflow out
        do_reset();
        bus_wr(2'd1, 32'h0FFF_2002);
        bus_wr(2'd0, GO);
        wait_n(300);
        bus_wr(2'd0, GO);
        wait_n(383);
        chk("R5 restart delays", {31'b0, sys_rst}, 0);
        wait_n(1);
        chk("R5 underflow after restart", {31'b0, sys_rst}, 1);

        // R10: idle halt
        do_reset();
        bus_wr(2'd1, 32'h1FFF_2001);
        bus_wr(2'd0, GO);
        idle = 1'b1;
        wait_n(600);
        chk("R10 idle frozen", {31'b0, sys_rst}, 0);
        bus_rd(2'd3, r);
        chk("R10 idle count", r, 1);
        idle = 1'b0;
        wait_n(255);
        chk("R10 idle before", {31'b0, sys_rst}, 0);
        wait_n(1);
        chk("R10 idle resume", {31'b0, sys_rst}, 1);

        // R10: debug halt
        do_reset();
        bus_wr(2'd1, 32'h2FFF_1001);
        bus_wr(2'd0, GO);
        dbg = 1'b1;
        wait_n(600);
        chk("R10 debug frozen", {31'b0, irq}, 0);
        dbg = 1'b0;
        wait_n(256);
        chk("R10 debug resume", {31'b0, irq}, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule